// File: doc/BRIEF.md
# Conversion Control Sequencer

This block is the digital control sequencer of a sampling converter. A host writes a small configuration word through a one-cycle write strobe. The word either parks the sequencer in a low-power standby state or sets it running. It also chooses between two ways of timing the acquisition window. In asynchronous mode an internal counter times the window, and its length is picked by a two-bit field. In synchronous mode the window closes on a rising edge of an external sync input.

When the window closes, the sequencer sends a one-cycle start pulse to an abstract converter core. It then waits for the core's done pulse and drives the ready line low to say a result is available. In asynchronous mode two things start a new window: a result read by the host, or a channel-changed strobe from the multiplexer logic. In that mode the shared sync pin is turned around into a busy output. Each time a conversion ends, the sequencer returns to a waiting state.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block is in standby with `rdy` high, `conv_start` low and `sync_oe` low (synchronous mode).
- R2: A configuration write with bit 3 clear (run command) issued in standby drives `rdy` low in the cycle after the write edge.
- R3: In asynchronous mode (bit 2 clear), a `rd_strobe` in the waiting state raises `rdy`. `conv_start` then pulses exactly N cycles after the read edge, where `cfg_wdata[1:0]` = 0,1,2,3 gives N = 9, 15, 47, 79.
- R4: In asynchronous mode a `chan_chg` strobe also opens the window, and every further `rd_strobe` or `chan_chg` during acquisition reloads the full count.
- R5: In asynchronous mode `sync_oe` is high and `sync_out` is high exactly while a conversion is in progress. In synchronous mode both are low.
- R6: In synchronous mode (bit 2 set), `cfg_wdata[1:0]` and `rd_strobe` have no effect. A rising edge on `sync_in` in the waiting state makes `conv_start` pulse in the cycle after that edge.
- R7: While `sync_oe` is high, `sync_in` has no effect on the sequencer.
- R8: `conv_start` lasts one cycle. `rdy` stays high until the `conv_done` pulse and falls in the cycle after it.
- R9: A configuration write with bit 3 set (standby command) forces standby with `rdy` high, and read or channel strobes then start nothing.
- R10: A change of mode written during acquisition or conversion takes effect only after the sequencer is back in the waiting or standby state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | [1:0] window select, [2] synchronous mode, [3] standby command |
| rd_strobe | input | 1 | Host has read the result |
| chan_chg | input | 1 | Multiplexer channel changed |
| sync_in | input | 1 | Sync pin input value |
| sync_out | output | 1 | Busy indication driven on the sync pin |
| sync_oe | output | 1 | Sync pin output enable |
| rdy | output | 1 | High while busy or in standby, low when a result is available |
| conv_start | output | 1 | One-cycle conversion request to the core |
| conv_done | input | 1 | Conversion-complete pulse from the core |

## Verification
The bench builds the sequencer with its default window lengths of 9, 15, 47 and 79 clocks. Even the longest window then fits in a short directed run, so the bench measures every select value cycle by cycle. It models the converter core with a fixed 40-cycle latency. That latency leaves room to write a mode change in the middle of a conversion and to watch the pin direction hold until the sequencer returns to the waiting state.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int CFG_W    = 4;
  localparam int SEL_LSB  = 0;
  localparam int SYNC_BIT = 2;
  localparam int STBY_BIT = 3;

  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACQ  = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
  import conv_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             apply,
  output logic             stby_we,
  output logic             run_we,
  output logic             mode_sync,
  output logic [1:0]       acq_sel
);
  logic       pend_sync_q;
  logic [1:0] pend_sel_q;
  logic       act_sync_q;
  logic [1:0] act_sel_q;

  assign stby_we = we & wdata[STBY_BIT];
  assign run_we  = we & ~wdata[STBY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sync_q <= 1'b1;
      pend_sel_q  <= 2'd0;
    end else if (we) begin
      pend_sync_q <= wdata[SYNC_BIT];
      pend_sel_q  <= wdata[SEL_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sync_q <= 1'b1;
      act_sel_q  <= 2'd0;
    end else if (apply) begin
      act_sync_q <= pend_sync_q;
      act_sel_q  <= pend_sel_q;
    end
  end

  assign mode_sync = act_sync_q;
  assign acq_sel   = act_sel_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sync_q) |-> $past(apply));
endmodule

// File: rtl/cs_acq_timer.sv
module cs_acq_timer #(
  parameter int ACQ_LEN0 = 9,
  parameter int ACQ_LEN1 = 15,
  parameter int ACQ_LEN2 = 47,
  parameter int ACQ_LEN3 = 79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] sel,
  output logic       expired
);
  localparam int MAX_A = (ACQ_LEN0 > ACQ_LEN1 ? ACQ_LEN0 : ACQ_LEN1) >
                         (ACQ_LEN2 > ACQ_LEN3 ? ACQ_LEN2 : ACQ_LEN3) ?
                         (ACQ_LEN0 > ACQ_LEN1 ? ACQ_LEN0 : ACQ_LEN1) :
                         (ACQ_LEN2 > ACQ_LEN3 ? ACQ_LEN2 : ACQ_LEN3);
  localparam int CNT_W = $clog2(MAX_A);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_val;

  always_comb begin
    case (sel)
      2'd0:    reload_val = CNT_W'(ACQ_LEN0 - 1);
      2'd1:    reload_val = CNT_W'(ACQ_LEN1 - 1);
      2'd2:    reload_val = CNT_W'(ACQ_LEN2 - 1);
      default: reload_val = CNT_W'(ACQ_LEN3 - 1);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = reload_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);
endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
  import conv_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby_we,
  input  logic run_we,
  input  logic mode_sync,
  input  logic start_req,
  input  logic sync_in,
  input  logic acq_expired,
  input  logic conv_done,
  output logic acq_load,
  output logic apply,
  output logic rdy,
  output logic conv_start,
  output logic in_conv
);
  seq_state_e state_q, state_d;
  logic       sync_prev_q;
  logic       conv_start_q;
  logic       sync_rise;

  assign sync_rise = mode_sync & sync_in & ~sync_prev_q;
  assign acq_load  = ~mode_sync & start_req &
                     ((state_q == ST_WAIT) | (state_q == ST_ACQ));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STBY: if (run_we)                   state_d = ST_WAIT;
      ST_WAIT: if (acq_load)                 state_d = ST_ACQ;
               else if (sync_rise)           state_d = ST_CONV;
      ST_ACQ:  if (!acq_load && acq_expired) state_d = ST_CONV;
      ST_CONV: if (conv_done)                state_d = ST_WAIT;
      default:                               state_d = ST_STBY;
    endcase
    if (stby_we) state_d = ST_STBY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_STBY;
      sync_prev_q  <= 1'b0;
      conv_start_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      sync_prev_q  <= sync_in;
      conv_start_q <= (state_d == ST_CONV) && (state_q != ST_CONV);
    end
  end

  assign apply      = (state_q == ST_STBY) | (state_q == ST_WAIT);
  assign rdy        = (state_q != ST_WAIT);
  assign conv_start = conv_start_q;
  assign in_conv    = (state_q == ST_CONV);

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R9
  stby_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_we |=> (rdy && !conv_start));
  // R3
  acq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && acq_expired && !acq_load && !stby_we) |=> conv_start);
  // R6
  sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && sync_rise && !stby_we) |=> conv_start);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int ACQ_LEN0 = 9,
  parameter int ACQ_LEN1 = 15,
  parameter int ACQ_LEN2 = 47,
  parameter int ACQ_LEN3 = 79
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rd_strobe,
  input  logic             chan_chg,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             sync_oe,
  output logic             rdy,
  output logic             conv_start,
  input  logic             conv_done
);
  logic       stby_we, run_we, mode_sync, apply;
  logic [1:0] acq_sel;
  logic       acq_load, acq_expired, in_conv;

  cs_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .apply     (apply),
    .stby_we   (stby_we),
    .run_we    (run_we),
    .mode_sync (mode_sync),
    .acq_sel   (acq_sel)
  );

  cs_acq_timer #(
    .ACQ_LEN0 (ACQ_LEN0),
    .ACQ_LEN1 (ACQ_LEN1),
    .ACQ_LEN2 (ACQ_LEN2),
    .ACQ_LEN3 (ACQ_LEN3)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (acq_load),
    .sel     (acq_sel),
    .expired (acq_expired)
  );

  cs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stby_we     (stby_we),
    .run_we      (run_we),
    .mode_sync   (mode_sync),
    .start_req   (rd_strobe | chan_chg),
    .sync_in     (sync_in),
    .acq_expired (acq_expired),
    .conv_done   (conv_done),
    .acq_load    (acq_load),
    .apply       (apply),
    .rdy         (rdy),
    .conv_start  (conv_start),
    .in_conv     (in_conv)
  );

  assign sync_oe  = ~mode_sync;
  assign sync_out = ~mode_sync & in_conv;

  // R5
  oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> sync_oe);
  // R7
  sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_oe && !rd_strobe && !chan_chg && !in_conv && !rdy) |=> !conv_start);
endmodule

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;
  localparam real CLK_P = 4.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [3:0] cfg_wdata;
  logic       rd_strobe, chan_chg, sync_in, conv_done;
  logic       sync_out, sync_oe, rdy, conv_start;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  conv_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_strobe(rd_strobe), .chan_chg(chan_chg), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .rdy(rdy),
    .conv_start(conv_start), .conv_done(conv_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
  endtask

  task automatic pulse_chg();
    chan_chg = 1'b1; tick(); chan_chg = 1'b0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!conv_start && n < 300) begin
      tick();
      n++;
    end
  endtask

  // Called at the negedge where conv_start is first seen high
  task automatic run_conv(input bit async_m);
    chk(sync_out == async_m, "R5 sync_out during conversion", sync_out, async_m);
    tick();
    chk(conv_start == 1'b0, "R8 start pulse width", conv_start, 0);
    repeat (38) tick();
    chk(rdy == 1'b1, "R8 rdy high before done", rdy, 1);
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk(rdy == 1'b0, "R8 rdy low after done", rdy, 0);
    chk(sync_out == 1'b0, "R5 sync_out after done", sync_out, 0);
  endtask

  task automatic t_reset();
    chk(rdy == 1'b1, "R1 rdy after reset", rdy, 1);
    chk(sync_oe == 1'b0, "R1 sync_oe after reset", sync_oe, 0);
    chk(conv_start == 1'b0, "R1 conv_start after reset", conv_start, 0);
  endtask

  task automatic t_standby_exit();
    write_cfg(4'b0000);
    chk(rdy == 1'b0, "R2 rdy after run command", rdy, 0);
    tick();
    chk(sync_oe == 1'b1, "R5 sync_oe in async mode", sync_oe, 1);
  endtask

  task automatic t_async_len(input logic [1:0] sel, input int exp_n);
    int n;
    write_cfg({2'b00, sel});
    tick();
    pulse_rd();
    chk(rdy == 1'b1, "R3 rdy high after read", rdy, 1);
    wait_start(n);
    chk(n == exp_n, "R3 acquisition length", n, exp_n);
    run_conv(1'b1);
  endtask

  task automatic t_chan_reload();
    int n;
    write_cfg(4'b0000);
    tick();
    pulse_chg();
    repeat (3) tick();
    chk(conv_start == 1'b0, "R4 no start before reload", conv_start, 0);
    pulse_chg();
    wait_start(n);
    chk(n == 9, "R4 window reloaded by channel change", n, 9);
    run_conv(1'b1);
  endtask

  task automatic t_async_ignores_sync();
    int seen = 0;
    sync_in = 1'b0; tick();
    sync_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (conv_start || rdy) seen++;
    end
    chk(seen == 0, "R7 sync_in ignored in async mode", seen, 0);
    sync_in = 1'b0; tick();
  endtask

  task automatic t_sync_mode();
    write_cfg(4'b0111);
    tick();
    chk(sync_oe == 1'b0, "R6 sync_oe low in sync mode", sync_oe, 0);
    pulse_rd();
    repeat (4) tick();
    chk(conv_start == 1'b0 && rdy == 1'b0, "R6 read ignored in sync mode",
        {conv_start, rdy}, 0);
    sync_in = 1'b1; tick();
    chk(conv_start == 1'b1, "R6 start on sync rising edge", conv_start, 1);
    run_conv(1'b0);
    sync_in = 1'b0; tick();
  endtask

  task automatic t_mode_defer();
    int n;
    write_cfg(4'b0000);
    tick();
    chk(sync_oe == 1'b1, "R10 async mode applied from idle", sync_oe, 1);
    pulse_rd();
    write_cfg(4'b0100);
    repeat (2) tick();
    chk(sync_oe == 1'b1, "R10 mode held during acquisition", sync_oe, 1);
    wait_start(n);
    chk(sync_oe == 1'b1, "R10 mode held at conversion start", sync_oe, 1);
    run_conv(1'b1);
    tick();
    chk(sync_oe == 1'b0, "R10 mode applied after return to idle", sync_oe, 0);
  endtask

  task automatic t_standby();
    int seen = 0;
    write_cfg(4'b1000);
    chk(rdy == 1'b1, "R9 rdy high in standby", rdy, 1);
    tick();
    pulse_rd();
    pulse_chg();
    for (int i = 0; i < 12; i++) begin
      tick();
      if (conv_start || !rdy) seen++;
    end
    chk(seen == 0, "R9 strobes ignored in standby", seen, 0);
    write_cfg(4'b0000);
    chk(rdy == 1'b0, "R2 rdy low on leaving standby", rdy, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    rd_strobe = 1'b0; chan_chg = 1'b0; sync_in = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_standby_exit();
    t_async_len(2'd0, 9);
    t_async_len(2'd1, 15);
    t_async_len(2'd2, 47);
    t_async_len(2'd3, 79);
    t_chan_reload();
    t_async_ignores_sync();
    t_sync_mode();
    t_mode_defer();
    t_standby();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule